// File: doc/BRIEF.md
# Reserved Instruction Trap Unit

This unit sits beside the decode stage. Each cycle it looks at the instruction being decoded and decides whether that instruction is a reserved encoding. Three things can make it reserved. The first is an unlisted major opcode. The second is an unlisted sub-field under the register-function or register-immediate major opcodes. The third is a 64-bit operation issued while the core runs in 32-bit user or supervisor mode. When the compressed 16-bit instruction set is enabled and the current instruction is 16-bit, the unit checks instead the minor fields of the register-register and 8-bit-immediate formats.

A valid reserved instruction makes the unit raise an exception request for one cycle. This request has no mask. It always selects the common exception vector. On the same clock edge the unit captures three values: the exception return address, the branch-delay flag and the 5-bit exception code. The return address points back to the preceding branch or jump when the instruction sits in a delay slot. In compressed mode it also points back to the extend prefix that the instruction follows, and bit 0 of the return address records the ISA mode.

All tables of defined encodings are parameters given as bit masks. A set bit means the encoding is defined. Any encoding whose bit is clear is reserved.

Top module: `rsvd_insn_trap`

## Requirements
- R1: In 32-bit decode, an instruction is reserved when bit `insn[31:26]` of the major-opcode table `MAJ_DEF` is clear.
- R2: In 32-bit decode, two further cases are reserved. With major opcode `SPECIAL_OP` (default 0), the instruction is reserved when bit `insn[5:0]` of `FUNC_DEF` is clear. With major opcode `REGIMM_OP` (default 1), it is reserved when bit `insn[20:16]` of `REGIMM_DEF` is clear.
- R3: 16-bit decode applies only when `cmp_en` and `isa16` are both 1; in every other case `isa16` has no effect. In 16-bit decode, `insn[15:11]` equal to `RR_OP` (default 5'b11101) is reserved when bit `insn[4:0]` of `RR_DEF` is clear. `insn[15:11]` equal to `I8_OP` (default 5'b01100) is reserved when bit `insn[10:8]` of `I8_DEF` is clear. Every other 16-bit major opcode is legal.
- R4: A 32-bit operation is a 64-bit operation when it is marked in `MAJ_IS64` by its major opcode, or in `FUNC_IS64` by its function field under `SPECIAL_OP`. Such an operation is reserved when `priv` is supervisor (1) or user (2, or 3) and `mode64` is 0. With `priv` = 0 (kernel) it is always legal, whatever the value of `mode64`.
- R5: When `cmp_en` is 0, the captured `exc_epc` is `prior_pc` if `in_dslot` is 1, and `insn_pc` otherwise. `exc_bd` equals `in_dslot`, and `after_ext` is ignored.
- R6: When `cmp_en` is 1, the captured address is `prior_pc` if `in_dslot` or `after_ext` is 1, and `insn_pc` otherwise. `exc_bd` is the OR of `in_dslot` and `after_ext`. Bit 0 of `exc_epc` is replaced by `isa16`.
- R7: `exc_req` is high in the cycle after a valid reserved instruction is sampled, and only then. An instruction sampled with `insn_vld` = 0 never raises it.
- R8: Whenever `exc_req` is high, `exc_vec_common` is high and `exc_code` is 10.
- R9: `exc_epc`, `exc_bd` and `exc_code` change only on a taken exception. A valid legal instruction leaves them unchanged, and so does an invalid slot.
- R10: After reset, `exc_req`, `exc_vec_common`, `exc_epc`, `exc_bd` and `exc_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_vld | input | 1 | Decode slot holds a real instruction |
| insn | input | 32 | Instruction word; a 16-bit instruction sits in bits 15:0 |
| insn_pc | input | PC_W | Address of the instruction |
| prior_pc | input | PC_W | Address of the preceding branch, jump or extend prefix |
| cmp_en | input | 1 | Compressed instruction set enabled |
| isa16 | input | 1 | Current instruction is 16-bit |
| in_dslot | input | 1 | Instruction is in a branch delay slot |
| after_ext | input | 1 | Instruction follows an extend prefix |
| priv | input | 2 | Privilege: 0 kernel, 1 supervisor, 2 user |
| mode64 | input | 1 | 64-bit operations enabled for the current non-kernel mode |
| exc_req | output | 1 | One-cycle reserved-instruction exception request |
| exc_vec_common | output | 1 | Common exception vector selected |
| exc_epc | output | PC_W | Captured exception return address |
| exc_bd | output | 1 | Captured branch-delay flag |
| exc_code | output | 5 | Captured exception code |

## Verification
The bench uses a 16-bit program counter and sets every lookup table explicitly. With these settings it can sweep every major opcode, every function code, every register-immediate selector and every compressed minor field. The opcode sweeps also run under all three privilege levels and both settings of the 64-bit enable. The narrow program counter keeps the return-address cases small enough to enumerate by hand: delay slot, extend prefix, ISA bit and the ignored prefix flag.

// File: rtl/rit_pkg.sv
package rit_pkg;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2
  } priv_e;

  localparam logic [4:0] EXC_CODE_RI = 5'd10;

  // 64-bit operations are legal in kernel mode, or where the mode enable allows them
  function automatic logic priv_allows64(input logic [1:0] priv, input logic mode64);
    return (priv == PRIV_KERNEL) || mode64;
  endfunction

  function automatic logic tbl64(input logic [63:0] tbl, input logic [5:0] idx);
    return tbl[idx];
  endfunction

  function automatic logic tbl32(input logic [31:0] tbl, input logic [4:0] idx);
    return tbl[idx];
  endfunction

  function automatic logic tbl8(input logic [7:0] tbl, input logic [2:0] idx);
    return tbl[idx];
  endfunction

endpackage

// File: rtl/rit_major_check.sv
module rit_major_check
  import rit_pkg::*;
#(
  parameter logic [63:0] MAJ_DEF    = '1,
  parameter logic [63:0] FUNC_DEF   = '1,
  parameter logic [31:0] REGIMM_DEF = '1,
  parameter logic [63:0] MAJ_IS64   = '0,
  parameter logic [63:0] FUNC_IS64  = '0,
  parameter logic [5:0]  SPECIAL_OP = 6'd0,
  parameter logic [5:0]  REGIMM_OP  = 6'd1
) (
  input  logic [5:0] major,
  input  logic [5:0] funct,
  input  logic [4:0] rsel,
  input  logic [1:0] priv,
  input  logic       mode64,
  output logic       hit_undef,
  output logic       hit_64
);

  logic is_special;
  logic is_regimm;
  logic op64;

  assign is_special = (major == SPECIAL_OP);
  assign is_regimm  = (major == REGIMM_OP);

  assign hit_undef = !tbl64(MAJ_DEF, major)
                   || (is_special && !tbl64(FUNC_DEF, funct))
                   || (is_regimm  && !tbl32(REGIMM_DEF, rsel));

  assign op64   = tbl64(MAJ_IS64, major) || (is_special && tbl64(FUNC_IS64, funct));
  assign hit_64 = op64 && !priv_allows64(priv, mode64);

endmodule

// File: rtl/rit_compact_check.sv
module rit_compact_check
  import rit_pkg::*;
#(
  parameter logic [31:0] RR_DEF = '1,
  parameter logic [7:0]  I8_DEF = '1,
  parameter logic [4:0]  RR_OP  = 5'b11101,
  parameter logic [4:0]  I8_OP  = 5'b01100
) (
  input  logic [15:0] half,
  output logic        hit
);

  logic [4:0] cmaj;
  logic       rr_bad;
  logic       i8_bad;

  assign cmaj   = half[15:11];
  assign rr_bad = (cmaj == RR_OP) && !tbl32(RR_DEF, half[4:0]);
  assign i8_bad = (cmaj == I8_OP) && !tbl8(I8_DEF, half[10:8]);
  assign hit    = rr_bad || i8_bad;

endmodule

// File: rtl/rit_capture.sv
module rit_capture
  import rit_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [PC_W-1:0] epc_d,
  input  logic            bd_d,
  output logic            exc_req,
  output logic            exc_vec_common,
  output logic [PC_W-1:0] exc_epc,
  output logic            exc_bd,
  output logic [4:0]      exc_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req        <= 1'b0;
      exc_vec_common <= 1'b0;
      exc_epc        <= '0;
      exc_bd         <= 1'b0;
      exc_code       <= '0;
    end else begin
      exc_req        <= take;
      exc_vec_common <= take;
      if (take) begin
        exc_epc  <= epc_d;
        exc_bd   <= bd_d;
        exc_code <= EXC_CODE_RI;
      end
    end
  end

endmodule

// File: rtl/rsvd_insn_trap.sv
module rsvd_insn_trap
  import rit_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter logic [63:0] MAJ_DEF    = 64'h3CFF_BFFF_0300_FFFF,
  parameter logic [63:0] FUNC_DEF   = 64'hFCFF_FFFF_0F3F_FF5D,
  parameter logic [31:0] REGIMM_DEF = 32'h001F_000F,
  parameter logic [63:0] MAJ_IS64   = 64'h0000_0000_0300_0000,
  parameter logic [63:0] FUNC_IS64  = 64'hFC00_F000_0000_0054,
  parameter logic [31:0] RR_DEF     = 32'hFFEF_F7FD,
  parameter logic [7:0]  I8_DEF     = 8'hF7,
  parameter logic [5:0]  SPECIAL_OP = 6'd0,
  parameter logic [5:0]  REGIMM_OP  = 6'd1,
  parameter logic [4:0]  RR_OP      = 5'b11101,
  parameter logic [4:0]  I8_OP      = 5'b01100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_vld,
  input  logic [31:0]     insn,
  input  logic [PC_W-1:0] insn_pc,
  input  logic [PC_W-1:0] prior_pc,
  input  logic            cmp_en,
  input  logic            isa16,
  input  logic            in_dslot,
  input  logic            after_ext,
  input  logic [1:0]      priv,
  input  logic            mode64,
  output logic            exc_req,
  output logic            exc_vec_common,
  output logic [PC_W-1:0] exc_epc,
  output logic            exc_bd,
  output logic [4:0]      exc_code
);

  // return-address choice; bit 0 carries the ISA mode when compressed mode is on
  function automatic logic [PC_W-1:0] pick_epc(
    input logic            c_en,
    input logic            is16,
    input logic            back,
    input logic [PC_W-1:0] pc,
    input logic [PC_W-1:0] prev
  );
    logic [PC_W-1:0] base;
    base = back ? prev : pc;
    if (c_en) base[0] = is16;
    return base;
  endfunction

  // named internal events used by the checker
  logic use16;
  logic hit_undef;
  logic hit_64;
  logic hit_cmp;
  logic hit_any;
  logic take;
  logic bd_d;
  logic [PC_W-1:0] epc_d;
  logic unused_rs;

  assign unused_rs = ^insn[25:21];

  rit_major_check #(
    .MAJ_DEF   (MAJ_DEF),
    .FUNC_DEF  (FUNC_DEF),
    .REGIMM_DEF(REGIMM_DEF),
    .MAJ_IS64  (MAJ_IS64),
    .FUNC_IS64 (FUNC_IS64),
    .SPECIAL_OP(SPECIAL_OP),
    .REGIMM_OP (REGIMM_OP)
  ) u_major (
    .major    (insn[31:26]),
    .funct    (insn[5:0]),
    .rsel     (insn[20:16]),
    .priv     (priv),
    .mode64   (mode64),
    .hit_undef(hit_undef),
    .hit_64   (hit_64)
  );

  rit_compact_check #(
    .RR_DEF(RR_DEF),
    .I8_DEF(I8_DEF),
    .RR_OP (RR_OP),
    .I8_OP (I8_OP)
  ) u_compact (
    .half(insn[15:0]),
    .hit (hit_cmp)
  );

  assign use16   = cmp_en && isa16;
  assign hit_any = use16 ? hit_cmp : (hit_undef || hit_64);
  assign take    = insn_vld && hit_any;
  assign bd_d    = in_dslot || (cmp_en && after_ext);
  assign epc_d   = pick_epc(cmp_en, isa16, bd_d, insn_pc, prior_pc);

  rit_capture #(
    .PC_W(PC_W)
  ) u_capture (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (take),
    .epc_d         (epc_d),
    .bd_d          (bd_d),
    .exc_req       (exc_req),
    .exc_vec_common(exc_vec_common),
    .exc_epc       (exc_epc),
    .exc_bd        (exc_bd),
    .exc_code      (exc_code)
  );

endmodule

// File: rtl/rsvd_insn_trap_chk.sv
module rsvd_insn_trap_chk
  import rit_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_vld,
  input logic [PC_W-1:0] prior_pc,
  input logic            cmp_en,
  input logic            isa16,
  input logic            in_dslot,
  input logic [1:0]      priv,
  input logic            take,
  input logic            hit_64,
  input logic            exc_req,
  input logic            exc_vec_common,
  input logic [PC_W-1:0] exc_epc,
  input logic            exc_bd,
  input logic [4:0]      exc_code
);

  // R7: an invalid slot never produces a request
  p_invalid_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_vld |=> !exc_req);

  // R8: request always comes with the common vector and the reserved code
  p_code_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_vec_common && exc_code == EXC_CODE_RI));

  // R9: captured state holds when nothing is taken
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(exc_epc) && $stable(exc_bd) && $stable(exc_code)));

  // R5: delay-slot fault without compressed mode points at the branch
  p_dslot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cmp_en && in_dslot) |=> (exc_bd && exc_epc == $past(prior_pc)));

  // R6: ISA mode recorded in bit 0
  p_isa_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmp_en) |=> (exc_epc[0] == $past(isa16)));

  // R4: kernel mode never flags a 64-bit operation
  p_kernel64_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_KERNEL) |-> !hit_64);

endmodule

bind rsvd_insn_trap rsvd_insn_trap_chk #(.PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_vld      (insn_vld),
  .prior_pc      (prior_pc),
  .cmp_en        (cmp_en),
  .isa16         (isa16),
  .in_dslot      (in_dslot),
  .priv          (priv),
  .take          (take),
  .hit_64        (hit_64),
  .exc_req       (exc_req),
  .exc_vec_common(exc_vec_common),
  .exc_epc       (exc_epc),
  .exc_bd        (exc_bd),
  .exc_code      (exc_code)
);

// File: tb/rsvd_insn_trap_tb.sv
module rsvd_insn_trap_tb;

  localparam int          PC_W = 16;
  localparam logic [63:0] T_MAJ  = 64'h3CFF_BFFF_0300_FFFF;
  localparam logic [63:0] T_FUN  = 64'hFCFF_FFFF_0F3F_FF5D;
  localparam logic [31:0] T_RIM  = 32'h001F_000F;
  localparam logic [63:0] T_M64  = 64'h0000_0000_0300_0000;
  localparam logic [63:0] T_F64  = 64'hFC00_F000_0000_0054;
  localparam logic [31:0] T_RR   = 32'hFFEF_F7FD;
  localparam logic [7:0]  T_I8   = 8'hF7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            insn_vld = 1'b0;
  logic [31:0]     insn = '0;
  logic [PC_W-1:0] insn_pc = '0;
  logic [PC_W-1:0] prior_pc = '0;
  logic            cmp_en = 1'b0;
  logic            isa16 = 1'b0;
  logic            in_dslot = 1'b0;
  logic            after_ext = 1'b0;
  logic [1:0]      priv = 2'd0;
  logic            mode64 = 1'b0;
  logic            exc_req;
  logic            exc_vec_common;
  logic [PC_W-1:0] exc_epc;
  logic            exc_bd;
  logic [4:0]      exc_code;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rsvd_insn_trap #(
    .PC_W(PC_W), .MAJ_DEF(T_MAJ), .FUNC_DEF(T_FUN), .REGIMM_DEF(T_RIM),
    .MAJ_IS64(T_M64), .FUNC_IS64(T_F64), .RR_DEF(T_RR), .I8_DEF(T_I8),
    .SPECIAL_OP(6'd0), .REGIMM_OP(6'd1), .RR_OP(5'b11101), .I8_OP(5'b01100)
  ) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reserved-ness restated from the requirements
  function automatic bit ref_rsvd(input logic [31:0] w, input bit c, input bit s16,
                                  input logic [1:0] p, input bit m);
    bit wide;
    if (c && s16) begin
      if (w[15:11] == 5'b11101) return ((T_RR >> w[4:0]) & 32'd1) == 0;
      if (w[15:11] == 5'b01100) return ((T_I8 >> w[10:8]) & 8'd1) == 0;
      return 0;
    end
    if (((T_MAJ >> w[31:26]) & 64'd1) == 0) return 1;
    if (w[31:26] == 6'd0 && ((T_FUN >> w[5:0]) & 64'd1) == 0) return 1;
    if (w[31:26] == 6'd1 && ((T_RIM >> w[20:16]) & 32'd1) == 0) return 1;
    wide = ((T_M64 >> w[31:26]) & 64'd1) != 0
        || (w[31:26] == 6'd0 && ((T_F64 >> w[5:0]) & 64'd1) != 0);
    return wide && p != 2'd0 && !m;
  endfunction

  // drive one decode slot at a falling edge, look at the result one cycle later
  task automatic slot(input bit v, input logic [31:0] w, input logic [PC_W-1:0] pc,
                      input logic [PC_W-1:0] pp, input bit c, input bit s16,
                      input bit ds, input bit ex, input logic [1:0] p, input bit m);
    insn_vld = v; insn = w; insn_pc = pc; prior_pc = pp; cmp_en = c; isa16 = s16;
    in_dslot = ds; after_ext = ex; priv = p; mode64 = m;
    @(negedge clk);
    insn_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    bit e;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 req", exc_req, 0);
    chk("R10 vec", exc_vec_common, 0);
    chk("R10 epc", exc_epc, 0);
    chk("R10 bd", exc_bd, 0);
    chk("R10 code", exc_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R4 sweep over major opcodes (function 0x20, selector 0 are defined)
    for (int mj = 0; mj < 64; mj++)
      for (int p = 0; p < 3; p++)
        for (int m = 0; m < 2; m++) begin
          w = {mj[5:0], 10'd0, 10'd0, 6'h20};
          e = ref_rsvd(w, 0, 0, p[1:0], m[0]);
          slot(1, w, 16'h1000, 16'h0FFC, 0, 0, 0, 0, p[1:0], m[0]);
          chk("R1_R4 major", exc_req, e);
          if (e) chk("R8 code", {exc_vec_common, exc_code}, {1'b1, 5'd10});
        end

    // R2/R4 sweep over function codes
    for (int f = 0; f < 64; f++)
      for (int p = 0; p < 3; p++)
        for (int m = 0; m < 2; m++) begin
          w = {6'd0, 20'd0, f[5:0]};
          e = ref_rsvd(w, 0, 0, p[1:0], m[0]);
          slot(1, w, 16'h1004, 16'h0FFC, 0, 0, 0, 0, p[1:0], m[0]);
          chk("R2_R4 funct", exc_req, e);
        end

    // R2 sweep over register-immediate selectors
    for (int r = 0; r < 32; r++) begin
      w = {6'd1, 5'd0, r[4:0], 16'd0};
      slot(1, w, 16'h1008, 16'h0FFC, 0, 0, 0, 0, 2'd2, 0);
      chk("R2 regimm", exc_req, ref_rsvd(w, 0, 0, 2'd2, 0));
    end

    // R3 sweeps over compressed minor fields
    for (int r = 0; r < 32; r++) begin
      w = {16'hFFFF, 5'b11101, 6'd0, r[4:0]};
      slot(1, w, 16'h2002, 16'h2000, 1, 1, 0, 0, 2'd2, 0);
      chk("R3 rr", exc_req, ref_rsvd(w, 1, 1, 2'd2, 0));
    end
    for (int r = 0; r < 8; r++) begin
      w = {16'h0000, 5'b01100, r[2:0], 8'h00};
      slot(1, w, 16'h2004, 16'h2000, 1, 1, 0, 0, 2'd1, 0);
      chk("R3 i8", exc_req, ref_rsvd(w, 1, 1, 2'd1, 0));
    end
    // R3 other 16-bit major legal even though upper bits hold a reserved 32-bit major
    slot(1, {6'h3F, 10'd0, 5'b00010, 11'd0}, 16'h2006, 16'h2000, 1, 1, 0, 0, 2'd2, 0);
    chk("R3 other16", exc_req, 0);

    // R5 return address without compressed mode (major 0x3F is reserved)
    slot(1, {6'h3F, 26'd0}, 16'h3001, 16'h2FF0, 0, 1, 0, 0, 2'd0, 0);
    chk("R5 plain epc", exc_epc, 16'h3001);
    chk("R5 plain bd", exc_bd, 0);
    slot(1, {6'h3F, 26'd0}, 16'h3104, 16'h3100, 0, 0, 1, 0, 2'd0, 0);
    chk("R5 dslot epc", exc_epc, 16'h3100);
    chk("R5 dslot bd", exc_bd, 1);
    slot(1, {6'h3F, 26'd0}, 16'h3208, 16'h3200, 0, 0, 0, 1, 2'd0, 0);
    chk("R5 ext ignored epc", exc_epc, 16'h3208);
    chk("R5 ext ignored bd", exc_bd, 0);

    // R6 compressed mode return address
    slot(1, {16'd0, 5'b11101, 6'd0, 5'd1}, 16'h4010, 16'h400C, 1, 1, 0, 0, 2'd0, 0);
    chk("R6 plain16 epc", exc_epc, 16'h4011);
    chk("R6 plain16 bd", exc_bd, 0);
    slot(1, {16'd0, 5'b11101, 6'd0, 5'd1}, 16'h4020, 16'h401C, 1, 1, 0, 1, 2'd0, 0);
    chk("R6 ext epc", exc_epc, 16'h401D);
    chk("R6 ext bd", exc_bd, 1);
    slot(1, {6'h3F, 26'd0}, 16'h4031, 16'h4029, 1, 0, 1, 0, 2'd0, 0);
    chk("R6 dslot32 epc", exc_epc, 16'h4028);
    chk("R6 dslot32 bd", exc_bd, 1);

    // R9 legal valid instruction leaves captured state unchanged
    slot(1, {6'd0, 20'd0, 6'h20}, 16'h5000, 16'h5550, 0, 0, 1, 0, 2'd0, 0);
    chk("R9 legal req", exc_req, 0);
    chk("R9 legal epc", exc_epc, 16'h4028);
    chk("R9 legal bd", exc_bd, 1);
    // R7 invalid reserved slot: no request, nothing captured
    slot(0, {6'h3F, 26'd0}, 16'h6000, 16'h6000, 0, 0, 0, 0, 2'd2, 0);
    chk("R7 invalid req", exc_req, 0);
    chk("R9 invalid epc", exc_epc, 16'h4028);
    chk("R9 invalid code", exc_code, 10);

    // R7 back-to-back reserved gives two requests, then drops
    slot(1, {6'h3F, 26'd0}, 16'h7000, 16'h0, 0, 0, 0, 0, 2'd0, 0);
    chk("R7 first", exc_req, 1);
    slot(1, {6'h3E, 26'd0}, 16'h7004, 16'h0, 0, 0, 0, 0, 2'd0, 0);
    chk("R7 second", exc_req, 1);
    chk("R7 second epc", exc_epc, 16'h7004);
    @(negedge clk);
    chk("R7 pulse ends", exc_req, 0);
    chk("R8 vec ends", exc_vec_common, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule